// File: doc/BRIEF.md
# Odd-Factor Prescaled Tick Divider

This block turns a fast system clock into a slow, regular strobe for a serial bus timing engine. The strobe is a clock enable: a pulse one system cycle wide. It is not a derived clock. The divide ratio comes from a 5-bit code split into two fields. The low field picks an odd base factor, and the high field picks a power-of-two prescale. The ratio is their product, so a single short code spans ratios from 1 up to 896. Typical codes bring input clocks from 4 MHz to 128 MHz down to about 1 MHz.

The code is captured when a write strobe is high. The same write clears both internal counters, so the new ratio starts from a known phase. Inside, a prescale counter runs on every cycle. Its wrap steps an odd-factor counter, and the wrap of that second counter becomes the registered tick.

Top module: `odd_tick_div`

## Requirements
- R1: Code bits [1:0] select the odd base factor: 00 gives 1, 01 gives 3, 10 gives 5, 11 gives 7 (for example code 0x02 gives 5, 0x03 gives 7).
- R2: Code bits [4:2] hold n, and the prescale is 2^n. The total ratio D is the odd factor times 2^n, from 1 to 896 (0x08 gives 4, 0x0C gives 8, 0x13 gives 112, 0x1C gives 128, 0x1F gives 896).
- R3: With no write, `tick` is high for exactly one cycle in every D cycles. When D is 1, `tick` is high on every cycle.
- R4: A rising edge with `div_wr` high loads `div_code` and clears both counters. `tick` is low after that edge. The first tick after it is registered on the D-th rising edge that follows the write edge.
- R5: A write on an edge where a tick would otherwise be registered suppresses that tick, and the new ratio restarts from zero.
- R6: While `rst_n` is low, `tick` is low. Reset loads code 0x00, so after reset release `tick` is high on every cycle.
- R7: Changes on `div_code` while `div_wr` is low have no effect on the tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_code | input | 5 | Divisor code: [4:2] prescale exponent, [1:0] odd factor select |
| div_wr | input | 1 | Load strobe for `div_code`; also restarts the counters |
| tick | output | 1 | One-cycle enable pulse, once every D cycles |

## Verification
A divisor write and the terminal count of the cascaded counters can land on the same rising edge. The bench provokes this on purpose. It follows its own phase model and raises `div_wr` exactly when the model predicts a terminal edge, both at ratio 5 and at ratio 1, where every edge is terminal. It then checks two things: no tick is registered on that edge, and the first tick under the new ratio comes exactly D cycles later. Random writes at arbitrary phases repeat this collision many more times, and a cycle-by-cycle comparison against the model judges each one.

// File: rtl/odd_tick_div_pkg.sv
package odd_tick_div_pkg;

  localparam int CODE_W    = 5;
  localparam int ODD_SEL_W = 2;
  localparam int PRE_SEL_W = CODE_W - ODD_SEL_W;
  localparam int PRE_CNT_W = (1 << PRE_SEL_W) - 1;
  localparam int ODD_CNT_W = ODD_SEL_W + 1;

  typedef struct packed {
    logic [PRE_SEL_W-1:0] pre_sel;
    logic [ODD_SEL_W-1:0] odd_sel;
  } div_code_t;

endpackage

// File: rtl/odd_tick_div_rst_sync.sv
module odd_tick_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/odd_tick_div_decode.sv
module odd_tick_div_decode
  import odd_tick_div_pkg::*;
(
  input  div_code_t              code,
  output logic [PRE_CNT_W-1:0]   pre_last,
  output logic [ODD_CNT_W-1:0]   odd_last
);

  // Odd factor 2s+1 counts 0..2s, so the terminal value is s shifted left.
  assign odd_last = {code.odd_sel, 1'b0};

  // Prescale 2^n counts 0..2^n-1: a mask of n low ones.
  for (genvar gi = 0; gi < PRE_CNT_W; gi++) begin : g_mask
    assign pre_last[gi] = (code.pre_sel > PRE_SEL_W'(gi));
  end

endmodule

// File: rtl/odd_tick_div_stage.sv
module odd_tick_div_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_last;
  logic         load_en;

  assign at_last = (cnt_q == last);
  assign wrap    = step & at_last;
  assign load_en = clr | step;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/odd_tick_div.sv
module odd_tick_div
  import odd_tick_div_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_CODE    = '0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              div_wr,
  output logic              tick
);

  logic                 rst_sync_n;
  div_code_t            code_q;
  logic [PRE_CNT_W-1:0] pre_last;
  logic [ODD_CNT_W-1:0] odd_last;
  logic [PRE_CNT_W-1:0] pre_cnt;
  logic [ODD_CNT_W-1:0] odd_cnt;
  logic                 pre_wrap;
  logic                 odd_wrap;
  logic                 tick_d;
  logic                 tick_q;

  odd_tick_div_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Divisor code register, loaded only on the write strobe.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q <= div_code_t'(RST_CODE);
    end else if (div_wr) begin
      code_q <= div_code_t'(div_code);
    end
  end

  odd_tick_div_decode u_decode (
    .code     (code_q),
    .pre_last (pre_last),
    .odd_last (odd_last)
  );

  // Power-of-two prescaler, advancing every cycle.
  odd_tick_div_stage #(.W(PRE_CNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (div_wr),
    .step  (1'b1),
    .last  (pre_last),
    .cnt   (pre_cnt),
    .wrap  (pre_wrap)
  );

  // Odd-factor counter, advancing on each prescaler wrap.
  odd_tick_div_stage #(.W(ODD_CNT_W)) u_odd (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (div_wr),
    .step  (pre_wrap),
    .last  (odd_last),
    .cnt   (odd_cnt),
    .wrap  (odd_wrap)
  );

  // A write on a terminal edge wins: no tick, fresh phase.
  always_comb begin
    tick_d = odd_wrap & ~div_wr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/odd_tick_div_chk.sv
module odd_tick_div_chk
  import odd_tick_div_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_sync_n,
  input logic                 div_wr,
  input logic [CODE_W-1:0]    div_code,
  input div_code_t            code_q,
  input logic                 tick,
  input logic [PRE_CNT_W-1:0] pre_cnt,
  input logic [ODD_CNT_W-1:0] odd_cnt,
  input logic [PRE_CNT_W-1:0] pre_last,
  input logic [ODD_CNT_W-1:0] odd_last
);

  logic ratio_one;
  assign ratio_one = (pre_last == '0) && (odd_last == '0);

  assert_quiet_in_reset_R6: assert property (@(posedge clk)
    !rst_n |-> !tick);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && !ratio_one) |=> !tick);

  assert_write_restart_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_wr |=> (pre_cnt == '0) && (odd_cnt == '0) && !tick);

  assert_write_loads_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_wr |=> (code_q == $past(div_code)));

  assert_code_held_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !div_wr |=> $stable(code_q));

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pre_cnt <= pre_last) && (odd_cnt <= odd_last));

endmodule

bind odd_tick_div odd_tick_div_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .div_wr     (div_wr),
  .div_code   (div_code),
  .code_q     (code_q),
  .tick       (tick),
  .pre_cnt    (pre_cnt),
  .odd_cnt    (odd_cnt),
  .pre_last   (pre_last),
  .odd_last   (odd_last)
);

// File: tb/odd_tick_div_tb_top.sv
module odd_tick_div_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_wr = 1'b0;
  logic [4:0] div_code = 5'h00;
  logic       tick;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Reference phase model
  int m_d  = 1;
  int m_ph = 0;
  bit m_tick = 1'b0;
  bit m_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  odd_tick_div dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_code (div_code),
    .div_wr   (div_wr),
    .tick     (tick)
  );

  function automatic int exp_div(logic [4:0] c);
    return (2 * int'(c[1:0]) + 1) << c[4:2];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 1'b0;
    end else if (div_wr) begin
      m_d    = exp_div(div_code);
      m_ph   = 0;
      m_tick = 1'b0;
      m_en   = 1'b1;
    end else begin
      m_tick = (m_ph == m_d - 1);
      m_ph   = m_tick ? 0 : m_ph + 1;
    end
  end

  // R3: cycle-by-cycle comparison once the model is aligned by a write
  always @(negedge clk) begin
    if (m_en && rst_n) check("R3 per-cycle", int'(tick), int'(m_tick));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Called at a negedge; returns at the negedge right after the write edge.
  task automatic wr(logic [4:0] c);
    div_code = c;
    div_wr   = 1'b1;
    @(negedge clk);
    div_wr   = 1'b0;
  endtask

  task automatic count_to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 4000);
  endtask

  task automatic first_and_period(string req, int d);
    int n;
    count_to_tick(n);
    check({req, " first tick"}, n, d);
    count_to_tick(n);
    check({req, " period"}, n, d);
  endtask

  task automatic directed(string req, logic [4:0] c, int d);
    wr(c);
    check("R4 low after write", int'(tick), 0);
    first_and_period(req, d);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));

    // R6: reset state
    repeat (4) @(negedge clk);
    check("R6 tick in reset", int'(tick), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check("R6 reset ratio 1", int'(tick), 1);
      @(negedge clk);
    end

    // R1: odd factors without prescale
    directed("R1 code 0x02", 5'h02, 5);
    directed("R1 code 0x03", 5'h03, 7);
    directed("R1 code 0x01", 5'h01, 3);
    directed("R1 code 0x00", 5'h00, 1);
    // R2: prescaled ratios
    directed("R2 code 0x08", 5'h08, 4);
    directed("R2 code 0x05", 5'h05, 6);
    directed("R2 code 0x0C", 5'h0C, 8);
    directed("R2 code 0x06", 5'h06, 10);
    directed("R2 code 0x09", 5'h09, 12);
    directed("R2 code 0x0F", 5'h0F, 56);
    directed("R2 code 0x13", 5'h13, 112);
    directed("R2 code 0x1C", 5'h1C, 128);
    directed("R2 code 0x1F", 5'h1F, 896);

    // R5: write on a terminal edge, ratio 5 -> 6
    wr(5'h02);
    while (m_ph != m_d - 1) @(negedge clk);
    wr(5'h05);
    check("R5 suppressed tick", int'(tick), 0);
    first_and_period("R5 restart", 6);

    // R5: ratio 1, every edge is terminal
    wr(5'h00);
    @(negedge clk);
    wr(5'h03);
    check("R5 suppressed at ratio 1", int'(tick), 0);
    first_and_period("R5 restart from 1", 7);

    // R7: code changes without strobe
    directed("R7 setup", 5'h06, 10);
    div_code = 5'h1F;
    count_to_tick(n);
    check("R7 period kept", n, 10);
    div_code = 5'h00;
    count_to_tick(n);
    check("R7 period kept again", n, 10);

    // Random writes at arbitrary phases (R3, R4, R5 via per-cycle model)
    for (int it = 0; it < 30; it++) begin
      logic [4:0] c;
      int run;
      c   = 5'($urandom_range(0, 31));
      run = $urandom_range(1, 1200);
      wr(c);
      for (int k = 0; k < run; k++) begin
        if ($urandom_range(0, 15) == 0) div_code = 5'($urandom_range(0, 31));
        @(negedge clk);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule